// File: doc/BRIEF.md
# Panel Power and Backlight Sequencer

This controller orders the three enables of a flat panel: the logic supply, the gate for the interface drivers, and the backlight lamp. On a power request it raises the supply first. It raises the interface gate only after the supply-good input is seen, and it raises the lamp only after the interface has been live for a programmed number of timebase ticks. When the request drops, it removes the enables in the reverse order, one per clock.

All delays are counted in ticks of a single-cycle timebase pulse, so one millisecond or one microsecond per tick is chosen by whoever drives that pulse. If supply-good does not arrive in time, the block parks in a fault state with every enable low. After any return to the off state, a minimum rest time must pass before a new power-up is taken. A 3-bit state output reports progress.

Top module: `panel_power_seq`

## Requirements
- R1: After reset the state output is 0 and all three enables are low. The state codes are: 0 off, 1 supply rising, 2 signals on, 3 lamp on, 4 powering down, 5 fault.
- R2: From off, a power request is taken only once OFF_TICKS ticks have been counted since off was entered (reset counts as entering off). The supply enable rises on the clock edge that takes the request, and the state becomes 1.
- R3: The interface enable rises only on an edge in state 1 at which supply-good and the request are both high. The state then becomes 2.
- R4: If SUPPLY_TIMEOUT ticks have been counted in state 1 without supply-good, the next edge moves to state 5 with all enables low.
- R5: The lamp enable rises only on an edge in state 2 after LAMP_DELAY ticks have been counted in that state. The state then becomes 3.
- R6: In state 4 each clock edge clears the highest enable still on, in the order lamp, interface, supply. The edge after all three are low returns the state to 0.
- R7: Dropping the request in state 1, 2 or 3 moves to state 4 on the next edge without changing any enable on that edge. A request raised again during state 4 has no effect.
- R8: State 5 is held while the request is high, even if supply-good returns. A low request moves the state to 0.
- R9: The interface enable is never high while the supply enable is low. The lamp enable is never high while the interface enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| powerReq | input | 1 | Panel power request, level |
| tickIn | input | 1 | One-cycle timebase pulse used for all delays |
| supplyGood | input | 1 | Logic supply has reached its level |
| supplyEn | output | 1 | Logic supply enable |
| signalEn | output | 1 | Interface driver gate; drivers held low when 0 |
| lampEn | output | 1 | Backlight lamp enable |
| stateOut | output | 3 | Sequencer state code |

## Verification
The supply-timeout fault is the hardest case to reach from the ports. It needs a legal off rest, an accepted request, and then exactly SUPPLY_TIMEOUT ticks with supply-good held low. The stimulus gets there by driving the rest and timeout tick by tick, and it checks that the state is still 1 on the last counted tick and becomes 5 only one edge later. Early and reasserted requests are issued during the off rest and during power-down, so that their lack of effect shows on the enables.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_SUPPLY_UP = 3'd1,
    ST_SIGNALS   = 3'd2,
    ST_LAMP      = 3'd3,
    ST_POWERDOWN = 3'd4,
    ST_FAULT     = 3'd5
  } seqState_e;

  typedef struct packed {
    logic clear;
    logic count;
  } timerStrobe_t;
endpackage

// File: rtl/panel_seq_timer.sv
module panel_seq_timer
  import panel_seq_pkg::*;
#(
  parameter int OFF_TICKS      = 100,
  parameter int SUPPLY_TIMEOUT = 50,
  parameter int LAMP_DELAY     = 200
) (
  input  logic         clk,
  input  logic         rstN,
  input  timerStrobe_t strobe,
  output logic         offDone,
  output logic         supplyLate,
  output logic         lampReady
);
  localparam int MAX_A    = (OFF_TICKS > SUPPLY_TIMEOUT) ? OFF_TICKS : SUPPLY_TIMEOUT;
  localparam int MAX_LIM  = (MAX_A > LAMP_DELAY) ? MAX_A : LAMP_DELAY;
  localparam int CW       = $clog2(MAX_LIM + 1);
  localparam logic [CW-1:0] SAT_V   = CW'(MAX_LIM);
  localparam logic [CW-1:0] OFF_V   = CW'(OFF_TICKS);
  localparam logic [CW-1:0] LATE_V  = CW'(SUPPLY_TIMEOUT);
  localparam logic [CW-1:0] LAMP_V  = CW'(LAMP_DELAY);

  logic [CW-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               tickCnt <= '0;
    else if (strobe.clear)                   tickCnt <= '0;
    else if (strobe.count && tickCnt != SAT_V) tickCnt <= tickCnt + 1'b1;
  end

  assign offDone    = (tickCnt >= OFF_V);
  assign supplyLate = (tickCnt >= LATE_V);
  assign lampReady  = (tickCnt >= LAMP_V);

  // R5
  lamp_ready_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lampReady) |-> $past(strobe.count));
endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         powerReq,
  input  logic         tickIn,
  input  logic         supplyGood,
  input  logic         offDone,
  input  logic         supplyLate,
  input  logic         lampReady,
  output timerStrobe_t strobe,
  output logic         supplyEn,
  output logic         signalEn,
  output logic         lampEn,
  output seqState_e    state
);
  seqState_e nextState;
  logic nSupply, nSignal, nLamp;

  always_comb begin
    nextState = state;
    nSupply   = supplyEn;
    nSignal   = signalEn;
    nLamp     = lampEn;
    case (state)
      ST_OFF: if (powerReq && offDone) begin
        nextState = ST_SUPPLY_UP;
        nSupply   = 1'b1;
      end
      ST_SUPPLY_UP: begin
        if (!powerReq) nextState = ST_POWERDOWN;
        else if (supplyGood) begin
          nextState = ST_SIGNALS;
          nSignal   = 1'b1;
        end else if (supplyLate) begin
          nextState = ST_FAULT;
          nSupply   = 1'b0;
          nSignal   = 1'b0;
          nLamp     = 1'b0;
        end
      end
      ST_SIGNALS: begin
        if (!powerReq) nextState = ST_POWERDOWN;
        else if (lampReady) begin
          nextState = ST_LAMP;
          nLamp     = 1'b1;
        end
      end
      ST_LAMP: if (!powerReq) nextState = ST_POWERDOWN;
      ST_POWERDOWN: begin
        if (lampEn)        nLamp     = 1'b0;
        else if (signalEn) nSignal   = 1'b0;
        else if (supplyEn) nSupply   = 1'b0;
        else               nextState = ST_OFF;
      end
      ST_FAULT: begin
        nSupply = 1'b0;
        nSignal = 1'b0;
        nLamp   = 1'b0;
        if (!powerReq) nextState = ST_OFF;
      end
      default: begin
        nextState = ST_FAULT;
        nSupply   = 1'b0;
        nSignal   = 1'b0;
        nLamp     = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      supplyEn <= 1'b0;
      signalEn <= 1'b0;
      lampEn   <= 1'b0;
    end else begin
      state    <= nextState;
      supplyEn <= nSupply;
      signalEn <= nSignal;
      lampEn   <= nLamp;
    end
  end

  assign strobe.clear = (nextState != state);
  assign strobe.count = tickIn &&
    (state == ST_OFF || state == ST_SUPPLY_UP || state == ST_SIGNALS);

  // R2
  supply_after_rest_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supplyEn) |-> $past(offDone) && $past(powerReq));
  // R3
  signal_after_good_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(signalEn) |-> $past(supplyGood));
  // R5
  lamp_after_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lampEn) |-> $past(lampReady));
  // R4
  fault_all_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAULT) |-> !supplyEn && !signalEn && !lampEn);
  // R6
  single_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POWERDOWN) |-> $countones({$fell(supplyEn), $fell(signalEn), $fell(lampEn)}) <= 1);
  // R9
  signal_needs_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    signalEn |-> supplyEn);
  // R9
  lamp_needs_signal_chk: assert property (@(posedge clk) disable iff (!rstN)
    lampEn |-> signalEn);
endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import panel_seq_pkg::*;
#(
  parameter int OFF_TICKS      = 100,
  parameter int SUPPLY_TIMEOUT = 50,
  parameter int LAMP_DELAY     = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerReq,
  input  logic       tickIn,
  input  logic       supplyGood,
  output logic       supplyEn,
  output logic       signalEn,
  output logic       lampEn,
  output logic [2:0] stateOut
);
  timerStrobe_t strobe;
  logic offDone, supplyLate, lampReady;
  seqState_e state;

  panel_seq_timer #(
    .OFF_TICKS(OFF_TICKS), .SUPPLY_TIMEOUT(SUPPLY_TIMEOUT), .LAMP_DELAY(LAMP_DELAY)
  ) i_timer (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .offDone(offDone), .supplyLate(supplyLate), .lampReady(lampReady)
  );

  panel_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .powerReq(powerReq), .tickIn(tickIn),
    .supplyGood(supplyGood), .offDone(offDone), .supplyLate(supplyLate),
    .lampReady(lampReady), .strobe(strobe), .supplyEn(supplyEn),
    .signalEn(signalEn), .lampEn(lampEn), .state(state)
  );

  assign stateOut = state;

  // R7
  powerdown_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd4 && $past(stateOut) != 3'd4) |-> $stable({supplyEn, signalEn, lampEn}));
endmodule

// File: tb/test_panel_power_seq.sv
module test_panel_power_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerReq = 1'b0, tickIn = 1'b0, supplyGood = 1'b0;
  logic supplyEn, signalEn, lampEn;
  logic [2:0] stateOut;
  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  panel_power_seq #(.OFF_TICKS(3), .SUPPLY_TIMEOUT(4), .LAMP_DELAY(5)) i_panel_power_seq (
    .clk(clk), .rstN(rstN), .powerReq(powerReq), .tickIn(tickIn),
    .supplyGood(supplyGood), .supplyEn(supplyEn), .signalEn(signalEn),
    .lampEn(lampEn), .stateOut(stateOut)
  );

  // {req, good, tick, expSupply, expSignal, expLamp, expState[2:0]}
  localparam int NV = 27;
  localparam logic [8:0] VEC [NV] = '{
    9'b001_000_000, // R2 rest tick 1
    9'b101_000_000, // R2 early request ignored
    9'b101_000_000, // R2 rest tick 3
    9'b100_100_001, // R2 request taken
    9'b101_100_001, // R3 waiting for good
    9'b110_110_010, // R3 good -> signals
    9'b111_110_010, // R5 delay tick 1
    9'b111_110_010, // R5
    9'b111_110_010, // R5
    9'b111_110_010, // R5
    9'b111_110_010, // R5 tick 5, lamp not yet
    9'b110_111_011, // R5 lamp on
    9'b111_111_011, // R5 holds
    9'b010_111_100, // R7 drop, enables unchanged
    9'b010_110_100, // R6 lamp off
    9'b110_100_100, // R6 R7 signals off, reassert ignored
    9'b110_000_100, // R6 supply off
    9'b110_000_000, // R6 back to off
    9'b111_000_000, // R2 rest again
    9'b111_000_000, // R2
    9'b111_000_000, // R2
    9'b110_100_001, // R2 accepted
    9'b110_110_010, // R3 good already high
    9'b010_110_100, // R7 drop in signals state
    9'b000_100_100, // R6 signals off first
    9'b000_000_100, // R6 supply off
    9'b000_000_000  // R6 off
  };

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got sup/sig/lamp/state=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic g, input logic t);
    @(negedge clk);
    powerReq = r; supplyGood = g; tickIn = t;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [5:0] outs();
    return {supplyEn, signalEn, lampEn, stateOut};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 reset", outs(), 6'b000_000);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6]);
      check($sformatf("vector %0d", i), outs(), VEC[i][5:0]);
    end
    // R4 supply timeout
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    check("R2 request after rest", outs(), 6'b100_001);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1);
    check("R4 still waiting at limit", outs(), 6'b100_001);
    step(1'b1, 1'b0, 1'b0);
    check("R4 fault all low", outs(), 6'b000_101);
    step(1'b1, 1'b1, 1'b1);
    check("R8 fault held", outs(), 6'b000_101);
    step(1'b0, 1'b1, 1'b0);
    check("R8 fault exit", outs(), 6'b000_000);
    // R7 drop during supply rise
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    check("R7 supply up", outs(), 6'b100_001);
    step(1'b0, 1'b0, 1'b0);
    check("R7 powerdown entry", outs(), 6'b100_100);
    step(1'b0, 1'b0, 1'b0);
    check("R6 supply off", outs(), 6'b000_100);
    step(1'b0, 1'b0, 1'b0);
    check("R6 off", outs(), 6'b000_000);
    // R1 reset in mid-sequence
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    check("R9 signals with supply", outs(), 6'b110_010);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 reset mid-run", outs(), 6'b000_000);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule